// File: doc/BRIEF.md
# Ingress Virtual Output Queue Manager

This block keeps, on the ingress side of a switch, one queue of packet descriptors for each pair of destination port and traffic class. An arriving descriptor names a destination port, a 3-bit class (or arrives unmarked), a byte length and an opaque tag. The block places it at the tail of its queue, or throws it away at the tail when the queue's byte occupancy would climb above that queue's limit. A drop counter is kept for every queue.

Nothing leaves a queue on local readiness alone. Each queue holds a signed byte balance of credit that a remote egress scheduler fills through a grant input. A queue whose head packet is not covered by its balance raises its credit request line. When the balance covers the head packet, the packet is released and its length is taken off the balance. The descriptors of all queues share one pool of slots, and each queue is a linked list through that pool. Queue limits can be rewritten while traffic flows.

Top module: `voq_manager`

## Requirements
- R1: The queue index of a marked descriptor is port × 8 + class, that is the port bits above the three class bits. `deq_q` reports this index for every packet released.
- R2: A descriptor with `in_tc_vld` low is placed in class 0 of its port, whatever `in_tc` carries.
- R3: `crd_req[q]` is high exactly while queue q holds at least one packet and its credit balance is below the head packet's length. It rises in the cycle after the enqueue that needs it.
- R4: A queue releases its head packet only when its balance is at least the head length. A release lowers the balance by that length, and a grant of `gnt_bytes` to `gnt_q` raises it. Unused credit is kept for later packets.
- R5: Packets of one queue leave in the order they were accepted, each with its own tag and length.
- R6: An accepted descriptor whose length added to its queue's byte occupancy exceeds that queue's limit is dropped and not stored. The drop counter of that queue alone increments, and it can be read as `drop_cnt` for the queue chosen by `drop_sel`.
- R7: A write with `lim_we` replaces the limit of queue `lim_q` from the next cycle. A lowered limit applies only to later arrivals and never removes packets already queued. An arrival that brings occupancy exactly to the limit is stored.
- R8: `in_ready` is low while the descriptor pool has no free slot. A descriptor offered then is neither stored nor counted as a drop, and it is taken once a release frees a slot.
- R9: At most one packet is released per cycle. `deq_valid` pulses in the cycle after the selection. When several queues are eligible, they are served in rotating order starting after the queue served last.
- R10: After reset, no packet is released, every request line is low, every drop counter is zero, `in_ready` is high and every limit equals `DEFAULT_LIMIT`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Descriptor offered |
| in_ready | output | 1 | Pool has a free slot |
| in_port | input | PORT_W | Destination port |
| in_tc | input | 3 | Traffic class |
| in_tc_vld | input | 1 | Class marking present |
| in_len | input | LEN_W | Packet length in bytes |
| in_tag | input | TAG_W | Opaque descriptor tag |
| crd_req | output | NQ | Per-queue credit request |
| gnt_valid | input | 1 | Credit grant strobe |
| gnt_q | input | Q_W | Queue receiving the grant |
| gnt_bytes | input | LEN_W | Granted bytes |
| lim_we | input | 1 | Queue limit write strobe |
| lim_q | input | Q_W | Queue whose limit is written |
| lim_bytes | input | BYTE_W | New limit in bytes |
| drop_sel | input | Q_W | Queue whose drop counter is shown |
| drop_cnt | output | DROP_W | Drop counter of `drop_sel` |
| deq_valid | output | 1 | Packet released this cycle |
| deq_q | output | Q_W | Queue of the released packet |
| deq_len | output | LEN_W | Length of the released packet |
| deq_tag | output | TAG_W | Tag of the released packet |

## Verification
The bench builds the block with two ports (sixteen queues), a pool of only eight slots and a default limit of 1000 bytes. The small pool lets eight queued packets exhaust it and exercise the stall path, while two ports still cover the port bits of the queue index. The low limit makes the exact-fit and one-byte-over cases cheap to reach. Two queues loaded and granted in consecutive cycles expose the rotating release order.

// File: rtl/voq_pkg.sv
package voq_pkg;
  localparam int TCS  = 8;
  localparam int TC_W = 3;

  function automatic logic [TC_W-1:0] eff_class(input logic marked, input logic [TC_W-1:0] tc);
    return marked ? tc : '0;
  endfunction
endpackage

// File: rtl/voq_slot_pool.sv
module voq_slot_pool #(
  parameter int DEPTH = 32,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic             put,
  input  logic [PTR_W-1:0] put_idx,
  output logic             has_free,
  output logic [PTR_W-1:0] take_idx
);
  logic [DEPTH-1:0] free_map;
  logic [DEPTH-1:0] take_oh, put_oh;

  always_comb begin
    take_idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--)
      if (free_map[i]) take_idx = PTR_W'(i);
  end

  assign has_free = |free_map;
  assign take_oh  = take ? (DEPTH'(1) << take_idx) : '0;
  assign put_oh   = put  ? (DEPTH'(1) << put_idx)  : '0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) free_map <= '1;
    else        free_map <= (free_map & ~take_oh) | put_oh;
endmodule

// File: rtl/voq_rr_pick.sv
module voq_rr_pick #(
  parameter int N = 16,
  localparam int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req,
  output logic          valid,
  output logic [IW-1:0] idx
);
  logic [IW-1:0] last;

  always_comb begin
    valid = 1'b0;
    idx   = '0;
    for (int i = 1; i <= N; i++) begin
      int k;
      k = (int'(last) + i) % N;
      if (!valid && req[k]) begin
        valid = 1'b1;
        idx   = IW'(k);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)     last <= IW'(N - 1);
    else if (valid) last <= idx;
endmodule

// File: rtl/voq_manager.sv
module voq_manager
  import voq_pkg::*;
#(
  parameter int NUM_PORTS     = 4,
  parameter int POOL_DEPTH    = 32,
  parameter int LEN_W         = 14,
  parameter int TAG_W         = 8,
  parameter int BYTE_W        = 20,
  parameter int CRED_W        = 20,
  parameter int DROP_W        = 16,
  parameter int DEFAULT_LIMIT = 12000,
  localparam int PORT_W = $clog2(NUM_PORTS),
  localparam int NQ     = NUM_PORTS * TCS,
  localparam int Q_W    = $clog2(NQ),
  localparam int PTR_W  = $clog2(POOL_DEPTH),
  localparam int PKT_W  = $clog2(POOL_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [PORT_W-1:0] in_port,
  input  logic [TC_W-1:0]   in_tc,
  input  logic              in_tc_vld,
  input  logic [LEN_W-1:0]  in_len,
  input  logic [TAG_W-1:0]  in_tag,
  output logic [NQ-1:0]     crd_req,
  input  logic              gnt_valid,
  input  logic [Q_W-1:0]    gnt_q,
  input  logic [LEN_W-1:0]  gnt_bytes,
  input  logic              lim_we,
  input  logic [Q_W-1:0]    lim_q,
  input  logic [BYTE_W-1:0] lim_bytes,
  input  logic [Q_W-1:0]    drop_sel,
  output logic [DROP_W-1:0] drop_cnt,
  output logic              deq_valid,
  output logic [Q_W-1:0]    deq_q,
  output logic [LEN_W-1:0]  deq_len,
  output logic [TAG_W-1:0]  deq_tag
);
  function automatic logic fits_limit(input logic [BYTE_W-1:0] occ, input logic [LEN_W-1:0] len,
                                      input logic [BYTE_W-1:0] lim);
    return ((BYTE_W+1)'(occ) + (BYTE_W+1)'(len)) <= (BYTE_W+1)'(lim);
  endfunction

  function automatic logic covers(input logic signed [CRED_W-1:0] bal, input logic [LEN_W-1:0] len);
    return bal >= $signed(CRED_W'(len));
  endfunction

  function automatic logic signed [CRED_W-1:0] credit_next(
      input logic signed [CRED_W-1:0] bal, input logic add_en, input logic [LEN_W-1:0] add,
      input logic sub_en, input logic [LEN_W-1:0] sub);
    logic signed [CRED_W-1:0] a, s;
    a = add_en ? $signed(CRED_W'(add)) : '0;
    s = sub_en ? $signed(CRED_W'(sub)) : '0;
    return bal + a - s;
  endfunction

  // descriptor pool storage
  logic [PTR_W-1:0] nxt      [POOL_DEPTH];
  logic [LEN_W-1:0] slot_len [POOL_DEPTH];
  logic [TAG_W-1:0] slot_tag [POOL_DEPTH];

  // per-queue state
  logic [PTR_W-1:0]         head  [NQ];
  logic [PTR_W-1:0]         tail  [NQ];
  logic [PKT_W-1:0]         cnt   [NQ];
  logic [BYTE_W-1:0]        occ   [NQ];
  logic signed [CRED_W-1:0] bal   [NQ];
  logic [BYTE_W-1:0]        lim   [NQ];
  logic [DROP_W-1:0]        drops [NQ];

  // named internal events
  logic [Q_W-1:0]   enq_q;
  logic             enq_fire, enq_store, enq_drop;
  logic [NQ-1:0]    elig;
  logic [LEN_W-1:0] head_len [NQ];
  logic             arb_valid;
  logic [Q_W-1:0]   arb_idx;
  logic [PTR_W-1:0] alloc_idx, deq_slot;
  logic             pool_free;

  assign enq_q     = {in_port, eff_class(in_tc_vld, in_tc)};
  assign in_ready  = pool_free;
  assign enq_fire  = in_valid && in_ready;
  assign enq_store = enq_fire && fits_limit(occ[enq_q], in_len, lim[enq_q]);
  assign enq_drop  = enq_fire && !fits_limit(occ[enq_q], in_len, lim[enq_q]);
  assign deq_slot  = head[arb_idx];
  assign drop_cnt  = drops[drop_sel];

  always_comb
    for (int q = 0; q < NQ; q++) begin
      head_len[q] = slot_len[head[q]];
      elig[q]     = (cnt[q] != '0) && covers(bal[q], head_len[q]);
      crd_req[q]  = (cnt[q] != '0) && !covers(bal[q], head_len[q]);
    end

  voq_slot_pool #(.DEPTH(POOL_DEPTH)) u_pool (
    .clk(clk), .rst_n(rst_n), .take(enq_store), .put(arb_valid), .put_idx(deq_slot),
    .has_free(pool_free), .take_idx(alloc_idx));

  voq_rr_pick #(.N(NQ)) u_pick (
    .clk(clk), .rst_n(rst_n), .req(elig), .valid(arb_valid), .idx(arb_idx));

  always_ff @(posedge clk)
    if (enq_store) begin
      slot_len[alloc_idx] <= in_len;
      slot_tag[alloc_idx] <= in_tag;
      if (cnt[enq_q] != '0) nxt[tail[enq_q]] <= alloc_idx;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int q = 0; q < NQ; q++) begin
        head[q]  <= '0;
        tail[q]  <= '0;
        cnt[q]   <= '0;
        occ[q]   <= '0;
        bal[q]   <= '0;
        lim[q]   <= BYTE_W'(DEFAULT_LIMIT);
        drops[q] <= '0;
      end
      deq_valid <= 1'b0;
      deq_q     <= '0;
      deq_len   <= '0;
      deq_tag   <= '0;
    end else begin
      for (int q = 0; q < NQ; q++) begin
        logic ins, rem;
        ins = enq_store && (enq_q == Q_W'(q));
        rem = arb_valid && (arb_idx == Q_W'(q));
        if (ins && (cnt[q] == '0 || (rem && cnt[q] == PKT_W'(1))))
          head[q] <= alloc_idx;
        else if (rem)
          head[q] <= nxt[head[q]];
        if (ins) tail[q] <= alloc_idx;
        cnt[q] <= cnt[q] + (ins ? PKT_W'(1) : '0) - (rem ? PKT_W'(1) : '0);
        occ[q] <= occ[q] + (ins ? BYTE_W'(in_len) : '0) - (rem ? BYTE_W'(head_len[q]) : '0);
        bal[q] <= credit_next(bal[q], gnt_valid && (gnt_q == Q_W'(q)), gnt_bytes, rem, head_len[q]);
        if (lim_we && lim_q == Q_W'(q)) lim[q] <= lim_bytes;
        if (enq_drop && enq_q == Q_W'(q) && drops[q] != '1) drops[q] <= drops[q] + DROP_W'(1);
      end
      deq_valid <= arb_valid;
      deq_q     <= arb_idx;
      deq_len   <= head_len[arb_idx];
      deq_tag   <= slot_tag[deq_slot];
    end
endmodule

module voq_manager_chk #(
  parameter int NQ  = 32,
  parameter int Q_W = 5
) (
  input logic           clk,
  input logic           rst_n,
  input logic           in_valid,
  input logic           in_ready,
  input logic           enq_store,
  input logic           enq_drop,
  input logic [NQ-1:0]  elig,
  input logic [NQ-1:0]  crd_req,
  input logic           arb_valid,
  input logic [Q_W-1:0] arb_idx,
  input logic           deq_valid,
  input logic [Q_W-1:0] deq_q
);
  // R4
  pick_is_covered_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arb_valid |-> elig[arb_idx]);
  // R3
  req_not_eligible_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (crd_req & elig) == '0);
  // R6
  store_or_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({enq_store, enq_drop}));
  // R8
  stall_no_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ready) |-> !(enq_store || enq_drop));
  // R9
  release_follows_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arb_valid |=> (deq_valid && deq_q == $past(arb_idx)));
  // R9
  no_spurious_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !arb_valid |=> !deq_valid);
endmodule

bind voq_manager voq_manager_chk #(.NQ(NQ), .Q_W(Q_W)) u_voq_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .enq_store(enq_store), .enq_drop(enq_drop), .elig(elig), .crd_req(crd_req),
  .arb_valid(arb_valid), .arb_idx(arb_idx), .deq_valid(deq_valid), .deq_q(deq_q));

// File: tb/test_voq_manager.sv
module test_voq_manager;
  localparam int NP = 2, POOL = 8, LEN_W = 14, TAG_W = 8, BYTE_W = 20, DROP_W = 16;
  localparam int NQ = NP * 8, Q_W = 4, PORT_W = 1;

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_ready, in_tc_vld = 0;
  logic [PORT_W-1:0] in_port = '0;
  logic [2:0] in_tc = '0;
  logic [LEN_W-1:0] in_len = '0;
  logic [TAG_W-1:0] in_tag = '0;
  logic [NQ-1:0] crd_req;
  logic gnt_valid = 0;
  logic [Q_W-1:0] gnt_q = '0;
  logic [LEN_W-1:0] gnt_bytes = '0;
  logic lim_we = 0;
  logic [Q_W-1:0] lim_q = '0;
  logic [BYTE_W-1:0] lim_bytes = '0;
  logic [Q_W-1:0] drop_sel = '0;
  logic [DROP_W-1:0] drop_cnt;
  logic deq_valid;
  logic [Q_W-1:0] deq_q;
  logic [LEN_W-1:0] deq_len;
  logic [TAG_W-1:0] deq_tag;

  voq_manager #(.NUM_PORTS(NP), .POOL_DEPTH(POOL), .LEN_W(LEN_W), .TAG_W(TAG_W),
    .BYTE_W(BYTE_W), .CRED_W(20), .DROP_W(DROP_W), .DEFAULT_LIMIT(1000)) i_voq_manager (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_port(in_port),
    .in_tc(in_tc), .in_tc_vld(in_tc_vld), .in_len(in_len), .in_tag(in_tag), .crd_req(crd_req),
    .gnt_valid(gnt_valid), .gnt_q(gnt_q), .gnt_bytes(gnt_bytes), .lim_we(lim_we),
    .lim_q(lim_q), .lim_bytes(lim_bytes), .drop_sel(drop_sel), .drop_cnt(drop_cnt),
    .deq_valid(deq_valid), .deq_q(deq_q), .deq_len(deq_len), .deq_tag(deq_tag));

  always #5 clk = ~clk;

  int checks = 0, fails = 0, deq_seen = 0;
  int exp_q [NQ][$];
  int seq_log [$];
  bit done = 0;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  // scoreboard monitor: R1, R5
  always @(negedge clk) if (rst_n && deq_valid) begin
    deq_seen++;
    seq_log.push_back(int'(deq_q));
    if (exp_q[deq_q].size() == 0) chk(0, "R5 unexpected release", int'(deq_q), -1);
    else begin
      int e;
      e = exp_q[deq_q].pop_front();
      chk(int'(deq_tag) == e / 65536 && int'(deq_len) == e % 65536, "R5 tag/len",
          int'(deq_tag) * 65536 + int'(deq_len), e);
    end
  end

  // driver: pushes expectation when a store is predicted
  task automatic send(input int port, input int tc, input bit marked, input int len,
                      input int tag, input bit drop);
    int q;
    q = port * 8 + (marked ? tc : 0);
    in_valid = 1; in_port = PORT_W'(port); in_tc = 3'(tc); in_tc_vld = marked;
    in_len = LEN_W'(len); in_tag = TAG_W'(tag);
    if (!drop) exp_q[q].push_back(tag * 65536 + len);
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 0;
  endtask

  task automatic grant(input int q, input int bytes);
    gnt_valid = 1; gnt_q = Q_W'(q); gnt_bytes = LEN_W'(bytes);
    @(negedge clk);
    gnt_valid = 0;
  endtask

  task automatic set_limit(input int q, input int bytes);
    lim_we = 1; lim_q = Q_W'(q); lim_bytes = BYTE_W'(bytes);
    @(negedge clk);
    lim_we = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int drops_of(input int q);
    drop_sel = Q_W'(q);
    return 0;
  endfunction

  task automatic chk_drops(input int q, input int expv, input string req);
    int dummy;
    dummy = drops_of(q);
    #1;
    chk(int'(drop_cnt) == expv, req, int'(drop_cnt), expv);
  endtask

  initial begin
    #1_000_000;
    chk(0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    int base;
    idle(2);
    // R10 reset state
    chk(in_ready == 1, "R10 in_ready", int'(in_ready), 1);
    chk(crd_req == '0, "R10 crd_req", int'(crd_req), 0);
    chk(deq_valid == 0, "R10 deq_valid", int'(deq_valid), 0);
    chk_drops(5, 0, "R10 drop counter");
    rst_n = 1;
    idle(2);

    // R1 R3 R4: port 1 class 5 -> queue 13
    send(1, 5, 1, 100, 1, 0);
    chk(crd_req[13] == 1, "R3 request after enqueue", int'(crd_req[13]), 1);
    base = deq_seen;
    grant(13, 60);
    idle(2);
    chk(crd_req[13] == 1, "R4 partial credit keeps request", int'(crd_req[13]), 1);
    chk(deq_seen == base, "R4 no release on partial credit", deq_seen - base, 0);
    grant(13, 40);
    idle(3);
    chk(deq_seen == base + 1, "R1 R4 release on full credit", deq_seen - base, 1);
    chk(crd_req[13] == 0, "R3 request drops", int'(crd_req[13]), 0);

    // R2 unmarked -> queue 0, credit carried over (R4)
    grant(0, 200);
    chk(crd_req[0] == 0, "R3 empty queue no request", int'(crd_req[0]), 0);
    base = deq_seen;
    send(0, 6, 0, 50, 2, 0);
    send(0, 6, 0, 100, 3, 0);
    send(0, 6, 0, 100, 4, 0);
    idle(4);
    chk(deq_seen == base + 2, "R2 R4 releases from stored credit", deq_seen - base, 2);
    chk(crd_req[0] == 1, "R3 residual balance short", int'(crd_req[0]), 1);
    grant(0, 50);
    idle(3);
    chk(deq_seen == base + 3, "R4 remaining released", deq_seen - base, 3);

    // R6 R7 tail drop and runtime limit on queue 3
    set_limit(3, 300);
    send(0, 3, 1, 100, 10, 0);
    send(0, 3, 1, 100, 11, 0);
    send(0, 3, 1, 100, 12, 0);
    send(0, 3, 1, 1, 13, 1);
    chk_drops(3, 1, "R6 drop over limit");
    chk_drops(2, 0, "R6 neighbour counter untouched");
    send(0, 3, 1, 1, 14, 1);
    chk_drops(3, 2, "R6 second drop");
    set_limit(3, 100);
    send(0, 3, 1, 50, 15, 1);
    chk_drops(3, 3, "R7 lowered limit drops arrival");
    base = deq_seen;
    grant(3, 300);
    idle(6);
    chk(deq_seen == base + 3, "R7 queued packets kept", deq_seen - base, 3);
    send(0, 3, 1, 100, 16, 0);
    chk(crd_req[3] == 1, "R7 exact fit stored", int'(crd_req[3]), 1);
    chk_drops(3, 3, "R7 exact fit not dropped");
    grant(3, 100);
    idle(3);
    send(0, 3, 1, 101, 17, 1);
    chk_drops(3, 4, "R6 one byte over");

    // R8 pool exhaustion on queue 8
    for (int i = 0; i < POOL; i++) send(1, 0, 1, 10, 20 + i, 0);
    in_valid = 1; in_port = 1'b1; in_tc = 3'd0; in_tc_vld = 1; in_len = 10; in_tag = 28;
    exp_q[8].push_back(28 * 65536 + 10);
    #1;
    chk(in_ready == 0, "R8 stall when pool full", int'(in_ready), 0);
    idle(3);
    chk(in_ready == 0, "R8 stall held", int'(in_ready), 0);
    chk_drops(8, 0, "R8 stalled arrival not dropped");
    grant(8, 10);
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 0;
    base = deq_seen;
    grant(8, 80);
    idle(12);
    chk(deq_seen == base + 8, "R8 all pool packets released", deq_seen - base, 8);

    // R9 rotation between queues 1 and 2
    for (int i = 0; i < 3; i++) send(0, 1, 1, 10, 30 + i, 0);
    for (int i = 0; i < 3; i++) send(0, 2, 1, 10, 40 + i, 0);
    seq_log.delete();
    gnt_valid = 1; gnt_q = 1; gnt_bytes = 30;
    @(negedge clk);
    gnt_q = 2;
    @(negedge clk);
    gnt_valid = 0;
    idle(8);
    chk(seq_log.size() == 6, "R9 six releases", seq_log.size(), 6);
    for (int i = 0; i < 6 && i < seq_log.size(); i++)
      chk(seq_log[i] == ((i % 2 == 0) ? 1 : 2), "R9 rotating order", seq_log[i], (i % 2 == 0) ? 1 : 2);

    // R5 nothing left outstanding
    for (int q = 0; q < NQ; q++)
      chk(exp_q[q].size() == 0, "R5 outstanding", exp_q[q].size(), 0);
    finish_run();
  end
endmodule